// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block produces the read burst requests that pull one video frame out of a linear memory buffer. Configuration supplies the byte address of the first pixel, how many bytes each line occupies, how far apart consecutive lines start in memory, and the number of lines less one. On a frame-start pulse the generator walks the lines from top to bottom. It cuts each line into bursts of at most `MAX_BEATS` beats of `BEAT_BYTES` bytes, and the last piece of a line is a shorter burst when the line does not fill a whole one.

Requests leave on a valid/ready address channel. The generator keeps a count of accepted requests whose data has not yet returned. A one-cycle completion pulse from the memory side lowers that count, and no request is offered while the count sits at the programmed maximum. After the last line has been requested the generator stays quiet until the next frame-start pulse. That pulse also restarts a frame that is still in progress.

The configuration inputs are read live and must be held stable while a frame is being fetched. The outstanding limit may be changed only while no request is outstanding.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset `req_valid` stays low and the outstanding count is zero until the first `frame_start` pulse.
- R2: When `frame_start` is high at a clock edge, the first request of the new frame carries `cfg_base` and is offered from the next cycle on, provided the outstanding count is below the limit.
- R3: A line of N bytes takes ceil(N / BEAT_BYTES) beats. These go out as bursts of MAX_BEATS beats followed by one final burst with the remainder, and no burst crosses the end of its line. `req_len` is the beat count minus one.
- R4: Within a line, each burst address equals the previous burst address plus the previous beat count times BEAT_BYTES.
- R5: Line k (counting from 0) starts at `cfg_base + k * cfg_line_pitch`, whatever the line length is.
- R6: Exactly `cfg_lines_m1 + 1` lines are requested. After that `req_valid` stays low until the next `frame_start`.
- R7: An accepted request (`req_valid && req_ready`) raises the outstanding count by one and a `rd_done` pulse lowers it by one. Both in one cycle leave it unchanged. `req_valid` is low whenever the count equals `cfg_max_outstanding`, and high otherwise while lines remain.
- R8: While `req_valid` is high and `req_ready` is low, the request stays offered with the same `req_addr` and `req_len`, unless a `frame_start` arrives.
- R9: A `frame_start` during a frame abandons the remaining bursts. The next request is line 0 at `cfg_base`, and the whole burst sequence follows again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle pulse that (re)starts a frame |
| cfg_base | input | ADDR_W | Byte address of the first pixel of line 0 |
| cfg_line_bytes | input | LEN_W | Bytes fetched per line (at least 1) |
| cfg_line_pitch | input | LEN_W | Byte distance between starts of consecutive lines |
| cfg_lines_m1 | input | LINES_W | Number of lines minus one |
| cfg_max_outstanding | input | OUTS_W | Limit on accepted but uncompleted requests |
| req_valid | output | 1 | A burst request is offered |
| req_ready | input | 1 | The memory side accepts the offered request |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_len | output | BL_W | Beats in the burst minus one |
| rd_done | input | 1 | One-cycle pulse: one earlier request has completed |

## Verification
A wrong outstanding count shows up on the very next cycle as `req_valid` high at the limit or low below it. Because of that, the bench predicts `req_valid` every cycle from its own count of grants and completions. A slip in the within-line offset or the remaining beat count shows up at the next accepted request as a wrong address or length. A wrong line index or line start shows up at the first burst of the following line, or as a frame that stops early or runs on past its last line. The bench sweeps line lengths that fall exactly on, just below and just past a burst or beat boundary. It combines these with single and multiple lines, two credit limits, two grant patterns and a mid-frame restart.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;

  // Frame walk state of the line sequencer.
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

endpackage

// File: rtl/fb_line_walker.sv
module fb_line_walker
  import fb_scan_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [ADDR_W-1:0]  base,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [CNT_W-1:0]   last_idx,
  input  logic               line_done,
  output logic [ADDR_W-1:0]  line_start,
  output logic               running
);

  walk_state_e       st_q, st_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic              walk_en;

  assign walk_en = frame_start | (line_done & (st_q == WALK_RUN));

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    start_d = start_q;
    if (frame_start) begin
      st_d    = WALK_RUN;
      idx_d   = '0;
      start_d = base;
    end else if (line_done && st_q == WALK_RUN) begin
      if (idx_q == last_idx) begin
        st_d = WALK_IDLE;
      end else begin
        idx_d   = idx_q + 1'b1;
        start_d = start_q + ADDR_W'(pitch);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WALK_IDLE;
      idx_q   <= '0;
      start_q <= '0;
    end else if (walk_en) begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      start_q <= start_d;
    end
  end

  assign line_start = start_q;
  assign running    = (st_q == WALK_RUN);

  AST_FRAME_LOADS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (running && line_start == $past(base))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WALK_IDLE && !frame_start) |=> (st_q == WALK_IDLE)); // R6

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WALK_RUN) |-> (idx_q <= last_idx)); // R6

endmodule

// File: rtl/fb_burst_cutter.sv
module fb_burst_cutter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 16,
  localparam int SH        = $clog2(BEAT_BYTES),
  localparam int BL_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
  localparam int BT_W      = LEN_W - SH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] line_start,
  input  logic [LEN_W-1:0]  line_len,
  input  logic              issue,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [BL_W-1:0]   burst_len,
  output logic              burst_ends_line
);

  logic [LEN_W:0]    len_round;
  logic [BT_W-1:0]   line_beats;
  logic [BT_W-1:0]   left_q, left_d;
  logic [BT_W-1:0]   cur_beats;
  logic [ADDR_W-1:0] off_q, off_d;
  logic              cut_en;

  // Round the line up to whole beats.
  assign len_round  = {1'b0, line_len} + (LEN_W+1)'(BEAT_BYTES - 1);
  assign line_beats = BT_W'(len_round >> SH);

  assign burst_ends_line = (left_q <= BT_W'(MAX_BEATS));
  assign cur_beats       = burst_ends_line ? left_q : BT_W'(MAX_BEATS);
  assign burst_len       = BL_W'(cur_beats - 1'b1);
  assign burst_addr      = line_start + off_q;

  assign cut_en = load | issue;

  always_comb begin
    off_d  = off_q;
    left_d = left_q;
    if (load) begin
      off_d  = '0;
      left_d = line_beats;
    end else if (issue) begin
      off_d  = off_q + (ADDR_W'(cur_beats) << SH);
      left_d = left_q - cur_beats;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      left_q <= '0;
    end else if (cut_en) begin
      off_q  <= off_d;
      left_q <= left_d;
    end
  end

  AST_BURST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (left_q != '0)); // R3

  AST_BURST_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ((off_q + (ADDR_W'(cur_beats) << SH)) <= (ADDR_W'(line_beats) << SH))); // R3

endmodule

// File: rtl/fb_credit_counter.sv
module fb_credit_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             give,
  input  logic [CNT_W-1:0] limit,
  output logic             has_room
);

  logic [CNT_W-1:0] count_q, count_d;
  logic             cnt_en;

  assign cnt_en = take ^ give;

  always_comb begin
    count_d = count_q;
    if (take && !give) begin
      count_d = count_q + 1'b1;
    end else if (give && !take && count_q != '0) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  assign has_room = (count_q < limit);

  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= limit); // R7

  AST_CREDIT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !give) |=> (count_q == $past(count_q) + 1'b1)); // R7

  AST_CREDIT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (give && !take && count_q != '0) |=> (count_q == $past(count_q) - 1'b1)); // R7

endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINES_W    = 12,
  parameter int OUTS_W     = 4,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BEATS  = 16,
  localparam int BL_W      = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LEN_W-1:0]   cfg_line_bytes,
  input  logic [LEN_W-1:0]   cfg_line_pitch,
  input  logic [LINES_W-1:0] cfg_lines_m1,
  input  logic [OUTS_W-1:0]  cfg_max_outstanding,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BL_W-1:0]    req_len,
  input  logic               rd_done
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe[1];

  logic              running;
  logic              has_room;
  logic              issue;
  logic              ends_line;
  logic              line_done;
  logic [ADDR_W-1:0] line_start;

  assign req_valid = running & has_room;
  assign issue     = req_valid & req_ready;
  assign line_done = issue & ends_line;

  fb_line_walker #(
    .ADDR_W  (ADDR_W),
    .PITCH_W (LEN_W),
    .CNT_W   (LINES_W)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .frame_start (frame_start),
    .base        (cfg_base),
    .pitch       (cfg_line_pitch),
    .last_idx    (cfg_lines_m1),
    .line_done   (line_done),
    .line_start  (line_start),
    .running     (running)
  );

  fb_burst_cutter #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .BEAT_BYTES (BEAT_BYTES),
    .MAX_BEATS  (MAX_BEATS)
  ) u_cutter (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .load            (frame_start | line_done),
    .line_start      (line_start),
    .line_len        (cfg_line_bytes),
    .issue           (issue),
    .burst_addr      (req_addr),
    .burst_len       (req_len),
    .burst_ends_line (ends_line)
  );

  fb_credit_counter #(
    .CNT_W (OUTS_W)
  ) u_credit (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .take     (issue),
    .give     (rd_done),
    .limit    (cfg_max_outstanding),
    .has_room (has_room)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_valid && !req_ready && !frame_start) |=>
      (req_valid && $stable(req_addr) && $stable(req_len))); // R8

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n_int |-> !req_valid); // R1

endmodule

// File: tb/fb_scan_addr_gen_test.sv
module fb_scan_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic [31:0] cfg_base;
  logic [15:0] cfg_line_bytes;
  logic [15:0] cfg_line_pitch;
  logic [11:0] cfg_lines_m1;
  logic [3:0]  cfg_max_outstanding;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [3:0]  req_len;
  logic        rd_done;

  always #2 clk = ~clk;

  fb_scan_addr_gen uut (
    .clk                 (clk),
    .rst_n               (rst_n),
    .frame_start         (frame_start),
    .cfg_base            (cfg_base),
    .cfg_line_bytes      (cfg_line_bytes),
    .cfg_line_pitch      (cfg_line_pitch),
    .cfg_lines_m1        (cfg_lines_m1),
    .cfg_max_outstanding (cfg_max_outstanding),
    .req_valid           (req_valid),
    .req_ready           (req_ready),
    .req_addr            (req_addr),
    .req_len             (req_len),
    .rd_done             (rd_done)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int pend   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one frame and predicts every request and every cycle of req_valid.
  task automatic run_frame(input int len, input int pitch, input int lm1,
                           input int maxo, input int mode, input int abort_at,
                           input logic [31:0] base);
    int  total, l, o, hs_total, guard;
    bit  done, aborted, hold_prev;
    logic [31:0] held_addr;
    // Drain completions left over from earlier frames.
    req_ready = 1'b0;
    while (pend > 0) begin
      rd_done = 1'b1;
      @(negedge clk);
      pend--;
    end
    rd_done             = 1'b0;
    cfg_base            = base;
    cfg_line_bytes      = 16'(len);
    cfg_line_pitch      = 16'(pitch);
    cfg_lines_m1        = 12'(lm1);
    cfg_max_outstanding = 4'(maxo);
    frame_start         = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    total     = (len + 7) / 8;
    l         = 0;
    o         = 0;
    done      = 1'b0;
    aborted   = 1'b0;
    hs_total  = 0;
    guard     = 0;
    hold_prev = 1'b0;
    held_addr = '0;
    while (!(done && pend == 0) && guard < 5000) begin
      bit restart, rdy, dn, hs, expv;
      int beats;
      logic [31:0] ea;
      string tag;
      guard++;
      restart = (abort_at > 0) && !aborted && (hs_total == abort_at);
      rdy     = restart ? 1'b0 : ((mode == 0) ? 1'b1 : ((cyc % 2) == 0));
      dn      = (pend > 0) && ((cyc % 3) != 1) && !restart;
      expv    = !done && (pend < maxo);
      chk(done ? "R6 req_valid after last line" : "R7 req_valid vs credit",
          32'(req_valid), 32'(expv));
      if (hold_prev && req_valid)
        chk("R8 address held while stalled", req_addr, held_addr);
      hs = req_valid && rdy;
      if (hs) begin
        beats = ((total - o) > 16) ? 16 : (total - o);
        ea    = base + 32'(l * pitch + o * 8);
        if (l == 0 && o == 0) tag = aborted ? "R9 restart address" : "R2 first address";
        else if (o == 0)      tag = "R5 line start address";
        else                  tag = "R4 burst address";
        chk(tag, req_addr, ea);
        chk("R3 burst length", 32'(req_len), 32'(beats - 1));
        o = o + beats;
        if (o == total) begin
          o = 0;
          l++;
          if (l > lm1) done = 1'b1;
        end
        hs_total++;
      end
      hold_prev = req_valid && !rdy && !restart;
      held_addr = req_addr;
      pend      = pend + int'(hs) - int'(dn);
      req_ready   = rdy;
      rd_done     = dn;
      frame_start = restart;
      @(negedge clk);
      frame_start = 1'b0;
      if (restart) begin
        aborted   = 1'b1;
        l         = 0;
        o         = 0;
        done      = 1'b0;
        hold_prev = 1'b0;
      end
    end
    if (guard >= 5000) chk("R6 frame completion", 32'(0), 32'(1));
    req_ready = 1'b1;
    rd_done   = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R6 idle after frame", 32'(req_valid), 32'(0));
      @(negedge clk);
    end
    req_ready = 1'b0;
  endtask

  initial begin
    int lens [6];
    lens = '{1, 8, 120, 128, 129, 300};
    rst_n               = 1'b0;
    frame_start         = 1'b0;
    req_ready           = 1'b0;
    rd_done             = 1'b0;
    cfg_base            = '0;
    cfg_line_bytes      = 16'd8;
    cfg_line_pitch      = 16'd8;
    cfg_lines_m1        = '0;
    cfg_max_outstanding = 4'd1;
    repeat (4) @(negedge clk);
    chk("R1 valid low in reset", 32'(req_valid), 32'(0));
    rst_n     = 1'b1;
    req_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R1 valid low before frame_start", 32'(req_valid), 32'(0));
    end
    req_ready = 1'b0;

    for (int li = 0; li < 6; li++) begin
      for (int a = 0; a < 2; a++) begin
        for (int m = 0; m < 2; m++) begin
          for (int md = 0; md < 2; md++) begin
            int pit;
            pit = ((lens[li] + 7) / 8) * 8 + md * 64;
            run_frame(lens[li], pit, a * 3, (m == 0) ? 1 : 3, md, 0,
                      32'h0010_0000 + 32'(li * 32'h1000) + 32'(a * 8));
          end
        end
      end
    end

    // R9: restart in the middle of a frame.
    run_frame(300, 320, 3, 3, 0, 5, 32'h0040_0000);
    run_frame(129, 136, 2, 2, 1, 4, 32'h0050_0008);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog R6 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule